// File: doc/BRIEF.md
# Set-Associative Main TLB with Command Register Interface

This block holds the main translation table of a memory management unit. The table has a fixed 128 sets, and a parameter picks 2 or 4 ways for each set. Software reaches it through a small register file on a single write port. There are two descriptor registers (`pd_lo` for the virtual side, `pd_hi` for the physical side), an index register and a command register. A command register write runs one operation in the clock cycle of that write:

- search the set for a translation;
- choose a slot for a new entry;
- store an entry, with or without flushing the micro-TLBs;
- read an entry back.

A read-only build word describes the geometry. The same register select is used for reads, and read data is combinational.

A lookup checks every way of the set that the virtual page selects. An entry matches when it is valid and its page is equal to the page in `pd_lo`. Its address-space ID must also be equal, unless the entry is marked global. A miss and a multiple match are both reported through the index register.

A write into the table leaves `utlb_inv_o` raised for the following cycle, which tells the micro-TLBs to drop their contents. The second write variant leaves that output low.

Top module: `jtlb`

## Requirements
- R1: After reset, `pd_lo`, `pd_hi` and the index register all read 0, every entry is invalid, and a lookup then reports a miss.
- R2: An entry's linear index is set*WAYS+way. The set is `pd_lo[19:13]`, which are the page bits above the 8 KiB page offset.
- R3: The lookup command (code 1) compares the page (`pd_lo[31:13]`) and the ID (`pd_lo[7:0]`) against the valid entries (bit 10 set) of the selected set. On exactly one match it loads that entry's linear index into the index register.
- R4: When the lookup finds no match, the index register becomes 0x8000_0000, that is, the error flag in bit 31 is set.
- R5: When more than one way matches, the index register becomes 0x8000_0001. A store never rejects an entry that duplicates another one.
- R6: An entry with its global bit (`pd_lo` bit 8) set matches on page alone, whatever the ID.
- R7: The slot command (code 2) loads the index register with set*WAYS+way, where way is the lowest invalid way of the set addressed by `pd_lo`.
- R8: When every way of the set is valid, the slot command takes the way from that set's rotating pointer instead. The pointer starts at way 0 after reset and advances by one, wrapping, on each such choice.
- R9: The store commands (code 3 and code 4) write `pd_lo` and `pd_hi` to the entry named by the low index bits. Storing zeros invalidates that entry.
- R10: The read command (code 5) loads `pd_lo` and `pd_hi` from the entry named by the index register.
- R11: `utlb_inv_o` is high for exactly the cycle after a code 3 store. It stays low after a code 4 store and after every other command.
- R12: Register select 4 reads the build word:
  - bits 31:24 hold the version;
  - bits 23:20 hold log2 of the set count;
  - bits 19:16 hold log2 of the way count;
  - bits 15:12 hold the page code, where page size = 512 << code;
  - bits 11:6 hold the data micro-TLB size;
  - bits 5:0 hold the instruction micro-TLB size.
- R13: The register selects are 0 for `pd_lo`, 1 for `pd_hi`, 2 for the index register (writable by software at any time), 3 for the command register and 4 for the build word. Command codes 0, 6 and 7 change no register, no entry and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select for writes and reads |
| reg_wdata_i | input | 32 | Write data; command code in bits 2:0 |
| reg_rdata_o | output | 32 | Combinational read data of the selected register |
| utlb_inv_o | output | 1 | Micro-TLB invalidate pulse |

## Verification
The assertions take for granted that a command never shares a cycle with another register write, which the single write port enforces. They also assume that software keeps the index register inside the table before it issues a store or a read. The stimulus writes index values only below SETS*WAYS. It draws pages from a few sets and a few high-page values, so that full sets, victim rotation and accidental duplicates all occur. Directed sequences add deliberate duplicates, global entries, erasure and undefined command codes.

// File: rtl/jtlb_pkg.sv
package jtlb_pkg;
  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_PROBE    = 3'd1,
    CMD_SLOT     = 3'd2,
    CMD_STORE    = 3'd3,
    CMD_STORE_NI = 3'd4,
    CMD_READ     = 3'd5
  } jtlb_cmd_e;

  localparam logic [2:0] SEL_PDLO = 3'd0;
  localparam logic [2:0] SEL_PDHI = 3'd1;
  localparam logic [2:0] SEL_IDX  = 3'd2;
  localparam logic [2:0] SEL_CMD  = 3'd3;
  localparam logic [2:0] SEL_CFG  = 3'd4;

  localparam int VALID_BIT  = 10;
  localparam int GLOBAL_BIT = 8;
  localparam int ERR_BIT    = 31;
endpackage

// File: rtl/jtlb_array.sv
module jtlb_array #(
  parameter int SETS = 128,
  parameter int WAYS = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int IDX_W = SET_W + WAY_W,
  localparam int N     = SETS * WAYS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            widx_i,
  input  logic [31:0]                 wlo_i,
  input  logic [31:0]                 whi_i,
  input  logic [IDX_W-1:0]            ridx_i,
  output logic [31:0]                 rlo_o,
  output logic [31:0]                 rhi_o,
  input  logic [SET_W-1:0]            set_i,
  output logic [WAYS-1:0][31:0]       set_lo_o,
  input  logic                        adv_i,
  output logic [WAY_W-1:0]            rr_o
);
  logic [31:0]      lo_mem [N];
  logic [31:0]      hi_mem [N];
  logic [WAY_W-1:0] rr_q   [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        lo_mem[i] <= '0;
        hi_mem[i] <= '0;
      end
    end else if (we_i) begin
      lo_mem[widx_i] <= wlo_i;
      hi_mem[widx_i] <= whi_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (adv_i) begin
      rr_q[set_i] <= (rr_q[set_i] == WAY_W'(WAYS - 1)) ? '0 : rr_q[set_i] + 1'b1;
    end
  end

  assign rlo_o = lo_mem[ridx_i];
  assign rhi_o = hi_mem[ridx_i];
  assign rr_o  = rr_q[set_i];

  // linear index = set*WAYS + way, ways consecutive within a set
  for (genvar w = 0; w < WAYS; w++) begin : g_way_rd
    assign set_lo_o[w] = lo_mem[IDX_W'(set_i) * IDX_W'(WAYS) + IDX_W'(w)];
  end
endmodule

// File: rtl/jtlb_set_match.sv
module jtlb_set_match
  import jtlb_pkg::*;
#(
  parameter int WAYS       = 2,
  parameter int PAGE_SHIFT = 13
) (
  input  logic [WAYS-1:0][31:0] set_lo_i,
  input  logic [31:0]           key_i,
  output logic [WAYS-1:0]       hit_o,
  output logic [WAYS-1:0]       valid_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic page_eq, id_eq;
    assign valid_o[w] = set_lo_i[w][VALID_BIT];
    assign page_eq    = set_lo_i[w][31:PAGE_SHIFT] == key_i[31:PAGE_SHIFT];
    assign id_eq      = set_lo_i[w][GLOBAL_BIT] || (set_lo_i[w][7:0] == key_i[7:0]);
    assign hit_o[w]   = valid_o[w] && page_eq && id_eq;
  end
endmodule

// File: rtl/jtlb_victim.sv
module jtlb_victim #(
  parameter int WAYS = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] rr_i,
  output logic [WAY_W-1:0] way_o,
  output logic             full_o
);
  logic [WAY_W-1:0] free_way;

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) free_way = WAY_W'(w);
    end
  end

  assign full_o = &valid_i;
  assign way_o  = full_o ? rr_i : free_way;
endmodule

// File: rtl/jtlb.sv
module jtlb
  import jtlb_pkg::*;
#(
  parameter int SETS       = 128,
  parameter int WAYS       = 2,
  parameter int PAGE_SHIFT = 13,
  parameter int VERSION    = 3,
  parameter int UDTLB      = 8,
  parameter int UITLB      = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        utlb_inv_o
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int IDX_W = SET_W + WAY_W;
  localparam logic [31:0] CFG_WORD = {8'(VERSION), 4'(SET_W), 4'(WAY_W),
                                      4'(PAGE_SHIFT - 9), 6'(UDTLB), 6'(UITLB)};

  logic [31:0] lo_q, hi_q, idx_q;
  logic        inv_q;

  jtlb_cmd_e   cmd;
  logic        cmd_fire, arr_we, adv;
  logic [SET_W-1:0]       set_sel;
  logic [WAYS-1:0][31:0]  set_lo;
  logic [WAYS-1:0]        set_hit, set_valid;
  logic [31:0]            rd_lo, rd_hi;
  logic [WAY_W-1:0]       rr_way, vic_way, hit_way;
  logic                   vic_full;
  logic [31:0]            probe_res;
  int unsigned            n_hit;

  assign cmd      = jtlb_cmd_e'(reg_wdata_i[2:0]);
  assign cmd_fire = reg_we_i && (reg_sel_i == SEL_CMD);
  assign arr_we   = cmd_fire && (cmd == CMD_STORE || cmd == CMD_STORE_NI);
  assign set_sel  = lo_q[PAGE_SHIFT +: SET_W];

  jtlb_array #(.SETS(SETS), .WAYS(WAYS)) u_array (
    .clk_i, .rst_ni,
    .we_i(arr_we), .widx_i(idx_q[IDX_W-1:0]), .wlo_i(lo_q), .whi_i(hi_q),
    .ridx_i(idx_q[IDX_W-1:0]), .rlo_o(rd_lo), .rhi_o(rd_hi),
    .set_i(set_sel), .set_lo_o(set_lo),
    .adv_i(adv), .rr_o(rr_way)
  );

  jtlb_set_match #(.WAYS(WAYS), .PAGE_SHIFT(PAGE_SHIFT)) u_match (
    .set_lo_i(set_lo), .key_i(lo_q), .hit_o(set_hit), .valid_o(set_valid)
  );

  jtlb_victim #(.WAYS(WAYS)) u_victim (
    .valid_i(set_valid), .rr_i(rr_way), .way_o(vic_way), .full_o(vic_full)
  );

  assign adv = cmd_fire && (cmd == CMD_SLOT) && vic_full;

  always_comb begin
    n_hit   = 0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (set_hit[w]) begin
        n_hit   = n_hit + 1;
        hit_way = WAY_W'(w);
      end
    end
    if (n_hit == 0)      probe_res = 32'h8000_0000;
    else if (n_hit > 1)  probe_res = 32'h8000_0001;
    else                 probe_res = 32'({set_sel, hit_way});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      idx_q <= '0;
      inv_q <= 1'b0;
    end else begin
      inv_q <= cmd_fire && (cmd == CMD_STORE);
      if (reg_we_i) begin
        case (reg_sel_i)
          SEL_PDLO: lo_q  <= reg_wdata_i;
          SEL_PDHI: hi_q  <= reg_wdata_i;
          SEL_IDX:  idx_q <= reg_wdata_i;
          SEL_CMD: begin
            case (cmd)
              CMD_PROBE: idx_q <= probe_res;
              CMD_SLOT:  idx_q <= 32'({set_sel, vic_way});
              CMD_READ: begin
                lo_q <= rd_lo;
                hi_q <= rd_hi;
              end
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_sel_i)
      SEL_PDLO: reg_rdata_o = lo_q;
      SEL_PDHI: reg_rdata_o = hi_q;
      SEL_IDX:  reg_rdata_o = idx_q;
      SEL_CFG:  reg_rdata_o = CFG_WORD;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign utlb_inv_o = inv_q;

  // R9
  store_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(arr_we) |-> (rd_lo == $past(lo_q) && rd_hi == $past(hi_q)));

  // R10
  read_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_fire && cmd == CMD_READ) |-> (lo_q == rd_lo && hi_q == rd_hi));

  // R3
  probe_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cmd_fire && cmd == CMD_PROBE) && !idx_q[ERR_BIT]) |->
      (rd_lo[31:PAGE_SHIFT] == lo_q[31:PAGE_SHIFT] && rd_lo[VALID_BIT]));

  // R7
  victim_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cmd_fire && cmd == CMD_SLOT) && !$past(vic_full)) |->
      !$past(set_valid[vic_way]));

  // R11
  inv_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    utlb_inv_o |-> $past(arr_we));
endmodule

// File: tb/sim_jtlb.sv
module sim_jtlb;
  localparam int SETS = 128;
  localparam int WAYS = 2;
  localparam int N    = SETS * WAYS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  sel = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        inv;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];
  int          m_rr [SETS];

  always #10 clk = ~clk;

  jtlb #(.SETS(SETS), .WAYS(WAYS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .utlb_inv_o(inv)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] s, output logic [31:0] d);
    sel = s;
    #1;
    d = rdata;
  endtask

  function automatic bit m_match(logic [31:0] e, logic [31:0] key);
    return e[10] && (e[31:13] == key[31:13]) && (e[8] || e[7:0] == key[7:0]);
  endfunction

  function automatic logic [31:0] m_probe(logic [31:0] key);
    int s = int'(key[19:13]);
    int n = 0, hw = 0;
    for (int w = 0; w < WAYS; w++)
      if (m_match(m_lo[s * WAYS + w], key)) begin n++; hw = w; end
    if (n == 0) return 32'h8000_0000;
    if (n > 1)  return 32'h8000_0001;
    return 32'(s * WAYS + hw);
  endfunction

  function automatic logic [31:0] m_slot(logic [31:0] key);
    int s = int'(key[19:13]);
    for (int w = 0; w < WAYS; w++)
      if (!m_lo[s * WAYS + w][10]) return 32'(s * WAYS + w);
    begin
      int v = m_rr[s];
      m_rr[s] = (v + 1) % WAYS;
      return 32'(s * WAYS + v);
    end
  endfunction

  task automatic probe(string tag, logic [31:0] key);
    logic [31:0] d;
    wr(3'd0, key);
    wr(3'd3, 32'd1);
    rd(3'd2, d);
    chk(tag, d, m_probe(key));
  endtask

  // slot, then plain store; returns index used
  task automatic install(string tag, logic [31:0] lo, logic [31:0] hi, output int idx);
    logic [31:0] d, e;
    wr(3'd0, lo);
    wr(3'd1, hi);
    wr(3'd3, 32'd2);
    e = m_slot(lo);
    rd(3'd2, d);
    chk(tag, d, e);
    idx = int'(e);
    wr(3'd3, 32'd3);
    m_lo[idx] = lo; m_hi[idx] = hi;
    chk("R11 inv after store", 32'(inv), 32'd1);
  endtask

  function automatic logic [31:0] mk(int hi3, int set, bit g, int asid);
    return (32'(hi3) << 20) | (32'(set) << 13) | 32'h400 | (32'(g) << 8) | 32'(asid & 8'hff);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, a, b;
    int idx, s0;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    for (int s = 0; s < SETS; s++) m_rr[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd0, d); chk("R1 pd_lo reset", d, 32'h0);
    rd(3'd1, d); chk("R1 pd_hi reset", d, 32'h0);
    rd(3'd2, d); chk("R1 index reset", d, 32'h0);
    chk("R1 inv reset", 32'(inv), 32'd0);
    rd(3'd4, d); chk("R12 build word", d, {8'd3, 4'd7, 4'd1, 4'd4, 6'd8, 6'd4});
    probe("R1 R4 probe empty", mk(1, 5, 0, 5));

    a = mk(2, 9, 0, 5);
    install("R2 R7 first slot", a, 32'hABCD_0123, idx);
    chk("R2 linear index", 32'(idx), 32'(9 * WAYS));
    probe("R3 probe hit", a);
    probe("R4 probe other id", mk(2, 9, 0, 6));
    wr(3'd0, a); wr(3'd3, 32'd1);
    rd(3'd2, d); chk("R3 probe idx", d, 32'(9 * WAYS));

    b = mk(3, 9, 1, 7);
    install("R7 second free way", b, 32'h5555_AAAA, idx);
    chk("R2 way1 index", 32'(idx), 32'(9 * WAYS + 1));
    probe("R6 global any id", mk(3, 9, 0, 8'h99));

    // read back the global entry
    wr(3'd0, 32'h0); wr(3'd1, 32'h0);
    wr(3'd2, 32'(9 * WAYS + 1));
    wr(3'd3, 32'd5);
    rd(3'd0, d); chk("R10 read lo", d, b);
    rd(3'd1, d); chk("R10 read hi", d, 32'h5555_AAAA);
    chk("R11 no inv after read", 32'(inv), 32'd0);

    // deliberate duplicate via store without flush
    wr(3'd0, a); wr(3'd1, 32'h1);
    wr(3'd2, 32'(9 * WAYS + 1));
    wr(3'd3, 32'd4);
    m_lo[9 * WAYS + 1] = a; m_hi[9 * WAYS + 1] = 32'h1;
    chk("R11 no inv after store_ni", 32'(inv), 32'd0);
    probe("R5 duplicate", a);
    rd(3'd2, d); chk("R5 dup code", d, 32'h8000_0001);

    // erase both
    for (int w = 0; w < WAYS; w++) begin
      wr(3'd0, 32'h0); wr(3'd1, 32'h0);
      wr(3'd2, 32'(9 * WAYS + w));
      wr(3'd3, 32'd3);
      m_lo[9 * WAYS + w] = '0; m_hi[9 * WAYS + w] = '0;
    end
    probe("R9 erased miss", a);
    rd(3'd2, d); chk("R9 erased code", d, 32'h8000_0000);

    // round robin on a full set
    s0 = 40;
    for (int k = 0; k < 5; k++) begin
      install("R8 slot sequence", mk(k, s0, 0, 3), 32'(k), idx);
      if (k >= WAYS) chk("R8 rotate", 32'(idx), 32'(s0 * WAYS + ((k - WAYS) % WAYS)));
    end

    // undefined codes leave everything alone
    wr(3'd0, 32'h1234_5400);
    wr(3'd2, 32'd7);
    wr(3'd3, 32'd6);
    chk("R13 code6 no inv", 32'(inv), 32'd0);
    wr(3'd3, 32'd0);
    wr(3'd3, 32'd7);
    rd(3'd0, d); chk("R13 pd_lo kept", d, 32'h1234_5400);
    rd(3'd2, d); chk("R13 index kept", d, 32'd7);
    rd(3'd3, d); chk("R13 cmd reads 0", d, 32'h0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom_range(0, 2));
      logic [31:0] key = mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
                            bit'($urandom_range(0, 1) == 0 && $urandom_range(0, 3) == 0),
                            int'($urandom_range(1, 4)));
      if (op == 0) begin
        install("R7 R8 random slot", key, $urandom, idx);
      end else if (op == 1) begin
        probe("R3 R4 R5 R6 random probe", key);
      end else begin
        int ri = int'($urandom_range(0, 8 * WAYS - 1));
        wr(3'd2, 32'(ri));
        wr(3'd3, 32'd5);
        rd(3'd0, d); chk("R10 random read lo", d, m_lo[ri]);
        rd(3'd1, d); chk("R10 random read hi", d, m_hi[ri]);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule